// File: doc/BRIEF.md
# Fetch-Block Branch Selector and Next Fetch Address Mux

This block keeps one 16-bit branch-selector word for every 16-byte fetch block and uses it to choose where instruction fetch goes next. Each word splits into eight 2-bit codes, one for each byte pair of the block. A code says whether a branch ends in that byte pair. If one does, the code also says whether it is a return or a conditional branch, and for a conditional branch it names which of two stored target slots holds the branch's target.

On each fetch, the block reads the word for the fetch address. It ignores the byte pairs that lie before the fetch offset. It then finds the lowest-addressed remaining code that redirects fetch. A return always redirects. A conditional branch redirects only when the direction prediction for its slot says taken. The block then drives the return-stack target, the target from the matching slot, or the start of the next sequential 16-byte block. A separate port takes selector codes from predecode, 4 bytes (two byte pairs) per cycle. An invalidate port clears the four words that belong to a replaced 64-byte cache line. A flag warns when the fetched word holds more branches than the fetch logic can serve.

Top module: `branch_sel_nextpc`

## Requirements
- R1: Pair p of a word (p = 0..7) covers bytes 2p and 2p+1 of the fetch block and sits in word bits [2p+1:2p]. The word for an address is entry fetch_addr[4+IDX_W-1:4]. Codes: 2'b00 none, 2'b01 return, 2'b10 conditional using slot 0, 2'b11 conditional using slot 1.
- R2: When the deciding code is a return, next_addr equals ret_target.
- R3: A slot-0 conditional decides only when pred_taken[0] is 1, and it gives slot0_target. A slot-1 conditional decides only when pred_taken[1] is 1, and it gives slot1_target. A conditional whose prediction is 0 is passed over.
- R4: When no code decides, next_addr is fetch_addr with bits [3:0] cleared, plus 16, for any fetch offset.
- R5: Codes in pairs below fetch_addr[3:1] have no effect on next_addr.
- R6: When several pairs qualify, the one with the lowest pair number decides.
- R7: A predecode write with pd_wr_en=1 selects entry pd_wr_addr[4+IDX_W-1:4] and chunk c = pd_wr_addr[3:2]. pd_wr_codes[1:0] goes to pair 2c and pd_wr_codes[3:2] to pair 2c+1. The word's other pairs keep their values. The new codes take effect from the next cycle.
- R8: inv_en=1 clears to 2'b00 all four words whose index bits [IDX_W-1:2] equal inv_addr[6+IDX_W-3:6], effective from the next cycle. Other words are unchanged.
- R9: When a write and an invalidate hit the same word in the same cycle, the invalidate wins and the word reads as all zero.
- R10: sel_conflict is 1 when the fetched word, counted over all eight pairs, holds more than one return code or more than two conditional codes. Otherwise it is 0.
- R11: After reset every word is zero, so next_addr is the sequential address and sel_conflict is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the selector words |
| fetch_addr | input | ADDR_W | Current fetch byte address |
| pred_taken | input | 2 | Direction prediction per target slot (bit 0 slot 0, bit 1 slot 1) |
| slot0_target | input | ADDR_W | Stored target for slot-0 conditionals |
| slot1_target | input | ADDR_W | Stored target for slot-1 conditionals |
| ret_target | input | ADDR_W | Return-stack top |
| pd_wr_en | input | 1 | Predecode write strobe |
| pd_wr_addr | input | ADDR_W | Byte address of the 4-byte chunk being written |
| pd_wr_codes | input | 4 | Two 2-bit codes for the chunk's pairs |
| inv_en | input | 1 | Cache line replacement invalidate strobe |
| inv_addr | input | ADDR_W | Address within the replaced 64-byte line |
| next_addr | output | ADDR_W | Chosen next fetch address |
| sel_conflict | output | 1 | Fetched word exceeds the branch budget |

## Verification
The assertions check four things on every cycle. At most one pair is chosen, and no chosen pair lies below the fetch offset. A return choice drives the return-stack target. A fall-through lands on a 16-byte boundary. After a predecode write or a line invalidate, the storage holds the written codes or zeros. Other behaviours can only be shown by the bench's scenarios. These are the merging of partial writes into a word, invalidate winning over a write to the same word, the priority order among mixed returns and conditionals under changing predictions, the exact sequential address from odd fetch offsets, and the conflict thresholds.

// File: rtl/bsel_pkg.sv
package bsel_pkg;
   localparam int BLK_BYTES  = 16;
   localparam int PAIR_CNT   = BLK_BYTES / 2;
   localparam int CODE_W     = 2;
   localparam int WORD_W     = PAIR_CNT * CODE_W;
   localparam int CHUNK_PAIR = 2;
   localparam int MAX_RET    = 1;
   localparam int MAX_COND   = 2;

   typedef enum logic [1:0] {
      SEL_NONE  = 2'b00,
      SEL_RET   = 2'b01,
      SEL_COND0 = 2'b10,
      SEL_COND1 = 2'b11
   } sel_code_e;
endpackage

// File: rtl/bsel_table.sv
module bsel_table
   import bsel_pkg::*;
#(
   parameter int IDX_W = 6
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [IDX_W-1:0]     rd_idx,
   output logic [WORD_W-1:0]    rd_word,
   input  logic                 wr_en,
   input  logic [IDX_W-1:0]     wr_idx,
   input  logic [1:0]           wr_chunk,
   input  logic [2*CODE_W-1:0]  wr_codes,
   input  logic                 inv_en,
   input  logic [IDX_W-3:0]     inv_line
);
   localparam int ENTRIES = 1 << IDX_W;
   localparam int LINE_W  = IDX_W - 2;
   localparam int CHUNK_W = CHUNK_PAIR * CODE_W;

   generate
      if (IDX_W < 2) begin : g_bad_idx
         $error("bsel_table: IDX_W must cover at least one 64-byte line");
      end
   endgenerate

   logic [WORD_W-1:0] word_q [ENTRIES];

   generate
      for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
         logic hit_inv;
         logic hit_wr;
         assign hit_inv = inv_en && (inv_line == LINE_W'(e / 4));
         assign hit_wr  = wr_en && (wr_idx == IDX_W'(e));
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               word_q[e] <= '0;
            end else if (hit_inv) begin
               word_q[e] <= '0;
            end else if (hit_wr) begin
               word_q[e][wr_chunk*CHUNK_W +: CHUNK_W] <= wr_codes;
            end
         end
      end
   endgenerate

   assign rd_word = word_q[rd_idx];

   // Assertion support: remember the last accepted write and invalidate.
   logic                wr_seen_q;
   logic [IDX_W-1:0]    wr_idx_q;
   logic [1:0]          wr_chunk_q;
   logic [CHUNK_W-1:0]  wr_codes_q;
   logic                inv_seen_q;
   logic [LINE_W-1:0]   inv_line_q;
   logic [CHUNK_W-1:0]  wr_slice;
   logic                line_clear;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_seen_q  <= 1'b0;
         inv_seen_q <= 1'b0;
         wr_idx_q   <= '0;
         wr_chunk_q <= '0;
         wr_codes_q <= '0;
         inv_line_q <= '0;
      end else begin
         wr_seen_q  <= wr_en && !(inv_en && inv_line == wr_idx[IDX_W-1:2]);
         wr_idx_q   <= wr_idx;
         wr_chunk_q <= wr_chunk;
         wr_codes_q <= wr_codes;
         inv_seen_q <= inv_en;
         inv_line_q <= inv_line;
      end
   end

   always_comb begin
      wr_slice   = word_q[wr_idx_q][wr_chunk_q*CHUNK_W +: CHUNK_W];
      line_clear = 1'b1;
      for (int k = 0; k < 4; k++) begin
         if (word_q[{inv_line_q, 2'(k)}] != '0) line_clear = 1'b0;
      end
   end

   assert_write_lands_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_seen_q |-> (wr_slice == wr_codes_q));

   assert_line_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
      inv_seen_q |-> line_clear);
endmodule

// File: rtl/bsel_scan.sv
module bsel_scan
   import bsel_pkg::*;
(
   input  logic [WORD_W-1:0]   word,
   input  logic [2:0]          start_pair,
   input  logic [1:0]          pred_taken,
   output logic [PAIR_CNT-1:0] pick_vec,
   output logic                any_pick,
   output sel_code_e           pick_code,
   output logic                conflict
);
   logic [PAIR_CNT-1:0] qual;
   logic [PAIR_CNT-1:0] is_ret;
   logic [PAIR_CNT-1:0] is_cond;
   logic [PAIR_CNT:0]   seen;

   assign seen[0] = 1'b0;

   generate
      for (genvar p = 0; p < PAIR_CNT; p++) begin : g_pair
         sel_code_e code;
         logic      redirect;
         assign code       = sel_code_e'(word[p*CODE_W +: CODE_W]);
         assign is_ret[p]  = (code == SEL_RET);
         assign is_cond[p] = (code == SEL_COND0) || (code == SEL_COND1);
         always_comb begin
            unique case (code)
               SEL_RET:   redirect = 1'b1;
               SEL_COND0: redirect = pred_taken[0];
               SEL_COND1: redirect = pred_taken[1];
               default:   redirect = 1'b0;
            endcase
         end
         assign qual[p]     = redirect && (3'(p) >= start_pair);
         assign pick_vec[p] = qual[p] && !seen[p];
         assign seen[p+1]   = seen[p] || qual[p];
      end
   endgenerate

   assign any_pick = seen[PAIR_CNT];

   always_comb begin
      logic [CODE_W-1:0] acc;
      acc = '0;
      for (int p = 0; p < PAIR_CNT; p++) begin
         if (pick_vec[p]) acc = acc | word[p*CODE_W +: CODE_W];
      end
      pick_code = sel_code_e'(acc);
   end

   always_comb begin
      int n_ret;
      int n_cond;
      n_ret  = 0;
      n_cond = 0;
      for (int p = 0; p < PAIR_CNT; p++) begin
         n_ret  = n_ret  + int'(is_ret[p]);
         n_cond = n_cond + int'(is_cond[p]);
      end
      conflict = (n_ret > MAX_RET) || (n_cond > MAX_COND);
   end
endmodule

// File: rtl/branch_sel_nextpc.sv
module branch_sel_nextpc
   import bsel_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int IDX_W  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] fetch_addr,
   input  logic [1:0]        pred_taken,
   input  logic [ADDR_W-1:0] slot0_target,
   input  logic [ADDR_W-1:0] slot1_target,
   input  logic [ADDR_W-1:0] ret_target,
   input  logic              pd_wr_en,
   input  logic [ADDR_W-1:0] pd_wr_addr,
   input  logic [3:0]        pd_wr_codes,
   input  logic              inv_en,
   input  logic [ADDR_W-1:0] inv_addr,
   output logic [ADDR_W-1:0] next_addr,
   output logic              sel_conflict
);
   localparam int BLK_SH  = $clog2(BLK_BYTES);
   localparam int LINE_SH = BLK_SH + 2;

   generate
      if (ADDR_W < LINE_SH + IDX_W) begin : g_bad_addr
         $error("branch_sel_nextpc: ADDR_W too narrow for IDX_W");
      end
   endgenerate

   logic [WORD_W-1:0]   cur_word;
   logic [PAIR_CNT-1:0] pick_vec;
   logic                any_pick;
   sel_code_e           pick_code;
   logic [ADDR_W-1:0]   seq_addr;

   bsel_table #(.IDX_W(IDX_W)) table_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_idx   (fetch_addr[BLK_SH +: IDX_W]),
      .rd_word  (cur_word),
      .wr_en    (pd_wr_en),
      .wr_idx   (pd_wr_addr[BLK_SH +: IDX_W]),
      .wr_chunk (pd_wr_addr[3:2]),
      .wr_codes (pd_wr_codes),
      .inv_en   (inv_en),
      .inv_line (inv_addr[LINE_SH +: IDX_W-2])
   );

   bsel_scan scan_i (
      .word       (cur_word),
      .start_pair (fetch_addr[3:1]),
      .pred_taken (pred_taken),
      .pick_vec   (pick_vec),
      .any_pick   (any_pick),
      .pick_code  (pick_code),
      .conflict   (sel_conflict)
   );

   assign seq_addr = {fetch_addr[ADDR_W-1:BLK_SH], {BLK_SH{1'b0}}} + ADDR_W'(BLK_BYTES);

   always_comb begin
      if (!any_pick) begin
         next_addr = seq_addr;
      end else begin
         unique case (pick_code)
            SEL_RET:   next_addr = ret_target;
            SEL_COND0: next_addr = slot0_target;
            SEL_COND1: next_addr = slot1_target;
            default:   next_addr = seq_addr;
         endcase
      end
   end

   logic [PAIR_CNT-1:0] below_mask;
   assign below_mask = (PAIR_CNT'(1) << fetch_addr[3:1]) - PAIR_CNT'(1);

   assert_single_pick_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(pick_vec));

   assert_skip_below_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (pick_vec & below_mask) == '0);

   assert_ret_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (any_pick && pick_code == SEL_RET) |-> (next_addr == ret_target));

   assert_seq_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !any_pick |-> (next_addr[BLK_SH-1:0] == '0));
endmodule

// File: tb/branch_sel_nextpc_tb.sv
module branch_sel_nextpc_tb_top;
   localparam int AW = 32;
   localparam logic [AW-1:0] RET_T = 32'hAAAA_0000;
   localparam logic [AW-1:0] T0    = 32'h5000_0100;
   localparam logic [AW-1:0] T1    = 32'h6000_0200;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] fetch_addr = '0;
   logic [1:0]    pred_taken = '0;
   logic          pd_wr_en = 1'b0;
   logic [AW-1:0] pd_wr_addr = '0;
   logic [3:0]    pd_wr_codes = '0;
   logic          inv_en = 1'b0;
   logic [AW-1:0] inv_addr = '0;
   logic [AW-1:0] next_addr;
   logic          sel_conflict;

   int n_chk = 0;
   int n_fail = 0;
   int cycles = 0;

   always #10 clk = ~clk;

   branch_sel_nextpc #(.ADDR_W(AW), .IDX_W(6)) dut_i (
      .clk(clk), .rst_n(rst_n), .fetch_addr(fetch_addr), .pred_taken(pred_taken),
      .slot0_target(T0), .slot1_target(T1), .ret_target(RET_T),
      .pd_wr_en(pd_wr_en), .pd_wr_addr(pd_wr_addr), .pd_wr_codes(pd_wr_codes),
      .inv_en(inv_en), .inv_addr(inv_addr),
      .next_addr(next_addr), .sel_conflict(sel_conflict)
   );

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 5000) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: got %0d cycles, expected fewer than 5000", cycles);
         finish_run();
      end
   end

   task automatic chk(string req, logic [AW-1:0] got, logic [AW-1:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   // Fetch probe: drive fetch/prediction, sample after settling, away from edges.
   task automatic probe(string req, logic [AW-1:0] fa, logic [1:0] pt, logic [AW-1:0] exp);
      @(negedge clk);
      fetch_addr = fa;
      pred_taken = pt;
      #2;
      chk(req, next_addr, exp);
   endtask

   task automatic probe_conf(string req, logic [AW-1:0] fa, logic exp);
      @(negedge clk);
      fetch_addr = fa;
      #2;
      chk(req, AW'(sel_conflict), AW'(exp));
   endtask

   task automatic wr_chunk(logic [AW-1:0] a, logic [3:0] codes);
      @(negedge clk);
      pd_wr_en = 1'b1; pd_wr_addr = a; pd_wr_codes = codes;
      @(negedge clk);
      pd_wr_en = 1'b0;
   endtask

   task automatic wr_word(logic [AW-1:0] blk, logic [15:0] w);
      for (int c = 0; c < 4; c++) wr_chunk(blk + AW'(4*c), w[4*c +: 4]);
   endtask

   task automatic t_reset();
      probe("R11 reset seq", 32'h0000_1240, 2'b11, 32'h0000_1250);
      probe_conf("R11 reset conflict", 32'h0000_1240, 1'b0);
   endtask

   task automatic t_return();
      wr_word(32'h0000_1240, 16'h0040);   // R1: pair 3 = return
      probe("R2 return", 32'h0000_1240, 2'b00, RET_T);
      probe("R1 pair3 covers byte 7", 32'h0000_1247, 2'b00, RET_T);
      probe("R5 return below offset", 32'h0000_1248, 2'b00, 32'h0000_1250);
      probe("R4 odd offset seq", 32'h0000_124B, 2'b11, 32'h0000_1250);
   endtask

   task automatic t_slot0();
      wr_word(32'h0000_1250, 16'h0008);   // pair 1 = cond slot 0
      probe("R3 slot0 taken", 32'h0000_1250, 2'b01, T0);
      probe("R3 slot0 not taken", 32'h0000_1250, 2'b00, 32'h0000_1260);
      probe("R3 slot0 other pred", 32'h0000_1250, 2'b10, 32'h0000_1260);
   endtask

   task automatic t_priority();
      wr_word(32'h0000_1260, 16'h1830);   // p2=slot1, p5=slot0, p6=return
      probe("R6 slot1 first", 32'h0000_1260, 2'b11, T1);
      probe("R6 skip to slot0", 32'h0000_1260, 2'b01, T0);
      probe("R6 fall to return", 32'h0000_1260, 2'b00, RET_T);
      probe("R5 offset at return", 32'h0000_126C, 2'b11, RET_T);
   endtask

   task automatic t_merge();
      wr_chunk(32'h0000_1264, 4'h0);      // clear pairs 2,3 only
      probe("R7 merged write", 32'h0000_1260, 2'b11, T0);
      probe("R7 other pairs kept", 32'h0000_126A, 2'b00, RET_T);
   endtask

   task automatic t_conflict();
      wr_word(32'h0000_1270, 16'h0005);   // two returns
      probe_conf("R10 two returns", 32'h0000_1270, 1'b1);
      wr_word(32'h0000_1270, 16'h002E);   // three conditionals
      probe_conf("R10 three conds", 32'h0000_1270, 1'b1);
      wr_word(32'h0000_1280, 16'h001E);   // slot0, slot1, return: within budget
      probe_conf("R10 within budget", 32'h0000_1280, 1'b0);
   endtask

   task automatic t_invalidate();
      @(negedge clk);
      inv_en = 1'b1; inv_addr = 32'h0000_1255;
      @(negedge clk);
      inv_en = 1'b0;
      probe("R8 entry cleared a", 32'h0000_1260, 2'b11, 32'h0000_1270);
      probe("R8 entry cleared b", 32'h0000_1240, 2'b00, 32'h0000_1250);
      probe_conf("R8 entry cleared c", 32'h0000_1270, 1'b0);
      probe("R8 next line kept", 32'h0000_1280, 2'b00, RET_T);
   endtask

   task automatic t_inv_wins();
      @(negedge clk);
      pd_wr_en = 1'b1; pd_wr_addr = 32'h0000_1240; pd_wr_codes = 4'h1;
      inv_en = 1'b1; inv_addr = 32'h0000_1270;
      @(negedge clk);
      pd_wr_en = 1'b0; inv_en = 1'b0;
      probe("R9 invalidate wins", 32'h0000_1240, 2'b11, 32'h0000_1250);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_return();
      t_slot0();
      t_priority();
      t_merge();
      t_conflict();
      t_invalidate();
      t_inv_wins();
      repeat (2) @(negedge clk);
      finish_run();
   end
endmodule